// File: doc/BRIEF.md
# Configurable-trigger interrupt controller

This block gathers 32 interrupt request lines into one combined interrupt output for a processor. Lines 0 to 15 are internal sources and always count as rising-edge events on an active-high signal. Lines 16 and up are external sources, up to sixteen of them. Two parameters set, for each external line, whether it is captured on an edge or on a level and whether it is active high or active low. Each line is first brought to an active-high form. An edge line then latches a status bit on a 0-to-1 change of that form; a level line latches it in every cycle the form is high.

Software reaches the block over a simple 32-bit register bus with word-wide accesses. It can read the captured status, the pending set (status masked by enable) and the enable mask. It writes the enable mask and clears events by writing ones to an acknowledge word. When a level line is acknowledged while it is still active, its status bit is set again at once, so the request is not lost. The output stays high while any enabled status bit is set.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset, status, pending and enable read as zero and `irq_out` is low.
- R2: Pending (read at byte offset 0x34) equals status AND enable, and `irq_out` is high exactly when pending is nonzero.
- R3: A line whose polarity bit is 0 is active low: a raw 0 counts as active and a raw 1 as inactive. Default external polarity is 16'h0F0F (lines 16-19 and 24-27 active high, 20-23 and 28-31 active low).
- R4: An edge line (all of lines 0-15; external lines whose trigger bit is 1, default 16'h00FF so lines 16-23) sets its status bit only on a 0-to-1 change of its active-high form. Holding it active after an acknowledge does not set the bit again.
- R5: A level line (default lines 24-31) sets its status bit in every cycle it is active. An acknowledge while it is still active leaves the bit set; once it is inactive, an acknowledge clears it.
- R6: A write to the acknowledge word (offset 0x3C) clears exactly the status bits written as 1. Bits written as 0 are kept, and a 1 written over a clear bit has no effect.
- R7: Bits under mask 0x40008787 are reserved in status, pending and enable. They read as zero, enable writes do not store them, and activity on those input lines never sets status.
- R8: Writes to status (offset 0x30) and pending (offset 0x34) have no effect.
- R9: A write to enable (offset 0x38) is reflected in pending and `irq_out` in the next cycle, and enable changes only on such a write.
- R10: If a new event on a line and an acknowledge of the same bit fall in the same cycle, the status bit stays set.
- R11: An access whose address has nonzero bits [1:0], or whose offset is not one of the four above, writes nothing and reads zero. The acknowledge word also reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines; bit index is the line number |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the same-cycle collision between a fresh edge event and an acknowledge of that same bit. The stimulus first latches the bit with a short pulse and lets the line fall. On a single falling clock edge it then raises the line again and issues the acknowledge write, so both land on the same rising edge. A second hard case is the acknowledge of a level line that is still held active. To reach it, the line stays asserted across the acknowledge write, and status is read back in the following cycle.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
    localparam int NUM_LINES = 32;
    localparam int INT_LINES = 16;
    localparam int MAX_EXT   = 16;

    localparam logic [NUM_LINES-1:0] RSV_MASK   = 32'h4000_8787;
    localparam logic [NUM_LINES-1:0] VALID_MASK = ~RSV_MASK;

    localparam logic [7:0] OFS_STATUS  = 8'h30;
    localparam logic [7:0] OFS_PENDING = 8'h34;
    localparam logic [7:0] OFS_ENABLE  = 8'h38;
    localparam logic [7:0] OFS_ACK     = 8'h3C;

    typedef struct packed {
        logic [NUM_LINES-1:0] status;
        logic [NUM_LINES-1:0] enable;
    } core_state_t;

    // Lines that exist: all internal ones plus the first n_ext external ones.
    function automatic logic [NUM_LINES-1:0] present_mask(input int n_ext);
        logic [NUM_LINES-1:0] m;
        for (int i = 0; i < NUM_LINES; i++) begin
            m[i] = (i < INT_LINES + n_ext);
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture
    import irq_trig_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] EDGE_CFG = '1,
    parameter logic [NUM_LINES-1:0] POL_CFG  = '1,
    parameter logic [NUM_LINES-1:0] PRESENT  = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw,
    output logic [NUM_LINES-1:0] norm,
    output logic [NUM_LINES-1:0] evt
);
    logic [NUM_LINES-1:0] prev_d, prev_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (!PRESENT[i]) begin : g_absent
            assign norm[i] = 1'b0;
            assign evt[i]  = 1'b0;
        end else begin : g_present
            // polarity 0 inverts the line so it becomes active high
            assign norm[i] = raw[i] ^ ~POL_CFG[i];
            if (EDGE_CFG[i]) begin : g_edge
                assign evt[i] = norm[i] & ~prev_q[i];
            end else begin : g_level
                assign evt[i] = norm[i];
            end
        end
    end

    always_comb begin
        prev_d = norm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irq_trig_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] evt,
    input  logic                 en_we,
    input  logic                 ack_we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] status,
    output logic [NUM_LINES-1:0] enable,
    output logic [NUM_LINES-1:0] pending,
    output logic                 irq
);
    core_state_t          st_d, st_q;
    logic [NUM_LINES-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = ack_we ? wdata : '0;
        if (en_we) st_d.enable = wdata & VALID_MASK;
        // clear first, then new events (level lines re-assert, new edges win)
        st_d.status = ((st_q.status & ~clr) | evt) & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status  = st_q.status;
    assign enable  = st_q.enable;
    assign pending = st_q.status & st_q.enable;
    assign irq     = |pending;
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_trig_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] status,
    input  logic [NUM_LINES-1:0] pending,
    input  logic [NUM_LINES-1:0] enable,
    output logic                 en_we,
    output logic                 ack_we,
    output logic [NUM_LINES-1:0] rdata
);
    logic aligned;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        en_we   = bus_en && bus_we && aligned && (bus_addr == ADDR_W'(OFS_ENABLE));
        ack_we  = bus_en && bus_we && aligned && (bus_addr == ADDR_W'(OFS_ACK));
        rdata   = '0;
        if (bus_en && !bus_we && aligned) begin
            if (bus_addr == ADDR_W'(OFS_STATUS))       rdata = status;
            else if (bus_addr == ADDR_W'(OFS_PENDING)) rdata = pending;
            else if (bus_addr == ADDR_W'(OFS_ENABLE))  rdata = enable;
        end
    end
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
    import irq_trig_pkg::*;
#(
    parameter int          NUM_EXT  = 16,
    parameter logic [15:0] EXT_EDGE = 16'h00FF,
    parameter logic [15:0] EXT_POL  = 16'h0F0F,
    parameter int          ADDR_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);
    localparam logic [NUM_LINES-1:0] EDGE_ALL = {EXT_EDGE, 16'hFFFF};
    localparam logic [NUM_LINES-1:0] POL_ALL  = {EXT_POL, 16'hFFFF};
    localparam logic [NUM_LINES-1:0] PRESENT  = present_mask(NUM_EXT);

    logic [NUM_LINES-1:0] norm_w, evt_w, status_w, enable_w, pending_w;
    logic [NUM_LINES-1:0] level_cfg_w;
    logic                 en_we_w, ack_we_w;

    assign level_cfg_w = ~EDGE_ALL & PRESENT;

    irq_line_capture #(
        .EDGE_CFG(EDGE_ALL), .POL_CFG(POL_ALL), .PRESENT(PRESENT)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .raw(irq_in), .norm(norm_w), .evt(evt_w)
    );

    irq_status_core u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt_w),
        .en_we(en_we_w), .ack_we(ack_we_w), .wdata(bus_wdata),
        .status(status_w), .enable(enable_w), .pending(pending_w), .irq(irq_out)
    );

    irq_bus_port #(.ADDR_W(ADDR_W)) u_bus (
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .status(status_w), .pending(pending_w), .enable(enable_w),
        .en_we(en_we_w), .ack_we(ack_we_w), .rdata(bus_rdata)
    );
endmodule

// File: rtl/irq_trig_checker.sv
module irq_trig_checker
    import irq_trig_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] bus_wdata,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] status,
    input logic [NUM_LINES-1:0] enable,
    input logic [NUM_LINES-1:0] evt,
    input logic [NUM_LINES-1:0] norm,
    input logic [NUM_LINES-1:0] level_cfg
);
    logic                 armed_q;
    logic                 en_wr;
    logic [NUM_LINES-1:0] ack_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign en_wr   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));
    assign ack_vec = (bus_en && bus_we && (bus_addr == ADDR_W'(OFS_ACK))) ? bus_wdata : '0;

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | enable) & RSV_MASK) == '0);

    assert_irq_matches_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(status & enable));

    assert_new_status_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((status & ~$past(status) & ~$past(evt)) == '0));

    assert_level_reassert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (($past(norm) & level_cfg & VALID_MASK & ~status) == '0));

    assert_ack_only_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (($past(status) & ~status & ~$past(ack_vec)) == '0));

    assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(en_wr)) |-> $stable(enable));
endmodule

bind irq_trigger_ctrl irq_trig_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
    .status(status_w), .enable(enable_w), .evt(evt_w), .norm(norm_w),
    .level_cfg(level_cfg_w)
);

// File: tb/tb_irq_trigger_ctrl.sv
module tb_irq_trigger_ctrl;
    localparam logic [31:0] IDLE = 32'hF0F0_0000; // active-low lines held inactive
    localparam logic [7:0]  A_ST = 8'h30, A_PD = 8'h34, A_EN = 8'h38, A_ACK = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = IDLE;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_trigger_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        step();
        rd(A_ST, v); check("R1 status", v, 0);
        rd(A_PD, v); check("R1 pending", v, 0);
        rd(A_EN, v); check("R1 enable", v, 0);
        check("R1 irq_out", {31'b0, irq_out}, 0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        set_in(IDLE | 32'h8); step();
        rd(A_ST, v); check("R4 edge set", v, 32'h8);
        wr(A_ACK, 32'h8);
        step();
        rd(A_ST, v); check("R4 held high no re-set", v, 0);
        set_in(IDLE); set_in(IDLE | 32'h8); step();
        rd(A_ST, v); check("R4 second edge", v, 32'h8);
        set_in(IDLE); wr(A_ACK, 32'h8);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        set_in(IDLE & ~32'h0010_0000); step();
        rd(A_ST, v); check("R3 active-low edge", v, 32'h0010_0000);
        wr(A_ACK, 32'h0010_0000);
        set_in(IDLE); step();
        rd(A_ST, v); check("R3 release not event", v, 0);
        set_in(IDLE | 32'h0001_0000); step();
        rd(A_ST, v); check("R3 active-high edge", v, 32'h0001_0000);
        set_in(IDLE); wr(A_ACK, 32'h0001_0000);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_in(IDLE | 32'h0100_0000); step();
        rd(A_ST, v); check("R5 level set", v, 32'h0100_0000);
        wr(A_ACK, 32'h0100_0000);
        rd(A_ST, v); check("R5 ack while active re-sets", v, 32'h0100_0000);
        set_in(IDLE); wr(A_ACK, 32'h0100_0000);
        rd(A_ST, v); check("R5 ack after release clears", v, 0);
        set_in(IDLE & ~32'h1000_0000); step();
        rd(A_ST, v); check("R5 R3 level active-low", v, 32'h1000_0000);
        set_in(IDLE); wr(A_ACK, 32'h1000_0000);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        set_in(IDLE | 32'h38); set_in(IDLE); step();
        rd(A_ST, v); check("R6 three set", v, 32'h38);
        wr(A_ACK, 32'h10);
        rd(A_ST, v); check("R6 only written bit cleared", v, 32'h28);
        wr(A_ACK, 32'h0004_0000);
        rd(A_ST, v); check("R6 ack of clear bit no effect", v, 32'h28);
        wr(A_ACK, 32'h28);
        rd(A_ST, v); check("R6 rest cleared", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        set_in(IDLE | 32'h8); set_in(IDLE); step();
        check("R2 disabled no irq", {31'b0, irq_out}, 0);
        wr(A_EN, 32'h10);
        check("R2 other bit enabled no irq", {31'b0, irq_out}, 0);
        wr(A_EN, 32'h8);
        check("R9 enable takes effect", {31'b0, irq_out}, 1);
        rd(A_PD, v); check("R2 pending", v, 32'h8);
        wr(A_EN, 32'h0);
        check("R9 disable drops irq", {31'b0, irq_out}, 0);
        rd(A_ST, v); check("R2 status kept", v, 32'h8);
        wr(A_ACK, 32'h8);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); check("R7 enable reserved masked", v, 32'hBFFF_7878);
        set_in(IDLE | 32'h8787); set_in(IDLE & ~32'h4000_0000); step();
        rd(A_ST, v); check("R7 reserved lines ignored", v, 0);
        check("R7 irq stays low", {31'b0, irq_out}, 0);
        set_in(IDLE); wr(A_EN, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        set_in(IDLE | 32'h20); set_in(IDLE); step();
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R8 status write ignored", v, 32'h20);
        wr(A_PD, 32'hFFFF_FFFF);
        rd(A_ST, v); check("R8 pending write ignored", v, 32'h20);
        rd(A_EN, v); check("R8 enable untouched", v, 0);
        wr(A_ACK, 32'h20);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        set_in(IDLE | 32'h10); set_in(IDLE); step();
        rd(A_ST, v); check("R10 pre set", v, 32'h10);
        @(negedge clk);
        irq_in = IDLE | 32'h10;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h10;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd(A_ST, v); check("R10 event wins over ack", v, 32'h10);
        set_in(IDLE); wr(A_ACK, 32'h10);
        rd(A_ST, v); check("R10 later ack clears", v, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(8'h39, 32'h8);
        rd(A_EN, v); check("R11 misaligned write ignored", v, 0);
        wr(8'h40, 32'h8);
        rd(A_EN, v); check("R11 unmapped write ignored", v, 0);
        set_in(IDLE | 32'h8); set_in(IDLE); step();
        rd(8'h31, v); check("R11 misaligned read zero", v, 0);
        rd(A_ACK, v); check("R11 ack reads zero", v, 0);
        wr(8'h3D, 32'h8);
        rd(A_ST, v); check("R11 misaligned ack ignored", v, 32'h8);
        wr(A_ACK, 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_polarity();
        t_level();
        t_ack();
        t_enable();
        t_reserved();
        t_readonly();
        t_collision();
        t_decode();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule